// File: doc/BRIEF.md
# Serial Transmit Byte Queue with Empty and End Flags

This block holds the bytes waiting to be sent by a serial transmitter. Software or a DMA engine pushes bytes into a 16-entry first-in first-out store through a write strobe. Each write carries a marker that says whether a DMA engine issued it. On every frame-time strobe, while transmit is enabled, one byte leaves the store toward the serializer. The byte appears on the output for one cycle, qualified by a valid pulse.

Alongside the data path, the block tracks the occupancy and keeps two status flags. The "room available" flag is set when the occupancy falls to a programmable watermark or below. The "line idle" flag is set once the store drains to zero. On the same events the block issues a one-cycle DMA request and raises a level transmit interrupt. The two flags clear only on a write that a DMA engine issued, never on a processor write. A queue-flush input empties the store and reports it as drained.

Top module: `tx_fifo_ctrl`

## Requirements
- R1: After reset the count is 0, `room_flag` and `idle_flag` are 1, and `tx_irq`, `dma_req` and `out_valid` are 0.
- R2: Accepted bytes leave in the order they were written, and `count` reports the number of bytes held, from 0 to 16.
- R3: A write is discarded when the store holds 16 bytes after any same-cycle departure. A discarded write changes no data, no count and no flag, whether or not it came from DMA.
- R4: A byte departs only on a cycle with `frame_tick`=1, `tx_en`=1 and `count`≠0. On the next cycle `out_valid` is 1 and `out_data` carries that byte. A tick that finds the store empty or transmit disabled changes nothing.
- R5: `trig_sel` chooses the watermark: 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2 and 2'b11 gives 1.
- R6: When a departure leaves the count at or below the watermark, the next cycle shows `room_flag`=1, a one-cycle `dma_req`, and `tx_irq`=1 if `irq_en`=1. If the count left is 0, `idle_flag` is also set.
- R7: An accepted write with `wr_dma`=1 clears `idle_flag`. If the count after that write is above the watermark, it also clears `room_flag` and `tx_irq`. A write with `wr_dma`=0 leaves all flags unchanged.
- R8: `flush`=1 empties the store, sets both flags and, if `irq_en`=1, raises `tx_irq` and pulses `dma_req`. A write or tick in the same cycle is ignored.
- R9: `tx_irq` is 0 in any cycle after one in which `irq_en` was 0.
- R10: When a departure and a write fall in the same cycle, the departure is judged against the count minus one, and the write is applied after it. The write's flag clearing therefore wins over the departure's flag setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 8 | Byte to push |
| wr_dma | input | 1 | Push was issued by a DMA engine |
| frame_tick | input | 1 | One frame time elapsed |
| tx_en | input | 1 | Transmit enable |
| trig_sel | input | 2 | Watermark select |
| flush | input | 1 | Empty the store |
| irq_en | input | 1 | Transmit interrupt enable |
| out_valid | output | 1 | Departing byte valid |
| out_data | output | 8 | Departing byte |
| count | output | 5 | Bytes held |
| room_flag | output | 1 | Count at or below watermark flag |
| idle_flag | output | 1 | Store drained flag |
| dma_req | output | 1 | One-cycle DMA request |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench drives the store to 16 bytes and keeps writing. A design that wraps the pointers or counts past 16 would then corrupt the order or report a count of 17. It sends DMA writes that land exactly on each watermark and one above it. A design with an off-by-one threshold would clear the room flag too early, or leave the interrupt standing. Departures and writes in the same cycle, and flushes mixed with writes, check the ordering rule and the flush priority. A design that judged the threshold after the write would show a wrong flag state. Processor writes above the watermark check that flags stay set, which a design that treated every write alike would get wrong.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int unsigned BYTE_W = 8;

  // Watermark chosen by the two select bits.
  function automatic logic [7:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = 8'd8;
      2'b01:   trig_level = 8'd4;
      2'b10:   trig_level = 8'd2;
      default: trig_level = 8'd1;
    endcase
  endfunction
endpackage

// File: rtl/tfifo_store.sv
module tfifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clear,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] occ_q, occ_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    occ_d = occ_q;
    if (clear) begin
      rd_d  = '0;
      wr_d  = '0;
      occ_d = '0;
    end else begin
      if (pop)  rd_d = bump(rd_q);
      if (push) wr_d = bump(wr_q);
      occ_d = occ_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_q] <= push_data;
  end

  assign head_data = mem[rd_q];
  assign occ       = occ_q;
endmodule

// File: rtl/tfifo_flags.sv
module tfifo_flags #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          pop,
  input  logic          push,
  input  logic          push_dma,
  input  logic [CW-1:0] occ_after_pop,
  input  logic [CW-1:0] occ_next,
  input  logic [CW-1:0] trig,
  input  logic          irq_en,
  output logic          room,
  output logic          idle,
  output logic          irq,
  output logic          dreq
);
  logic room_d, idle_d, irq_d, dreq_d;

  always_comb begin
    room_d = room;
    idle_d = idle;
    irq_d  = irq;
    dreq_d = 1'b0;
    if (clear) begin
      room_d = 1'b1;
      idle_d = 1'b1;
      if (irq_en) begin
        irq_d  = 1'b1;
        dreq_d = 1'b1;
      end
    end else begin
      if (pop && (occ_after_pop <= trig)) begin
        room_d = 1'b1;
        dreq_d = 1'b1;
        if (irq_en) irq_d = 1'b1;
        if (occ_after_pop == '0) idle_d = 1'b1;
      end
      if (push && push_dma) begin
        idle_d = 1'b0;
        if (occ_next > trig) begin
          room_d = 1'b0;
          irq_d  = 1'b0;
        end
      end
    end
    if (!irq_en) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      room <= 1'b1;
      idle <= 1'b1;
      irq  <= 1'b0;
      dreq <= 1'b0;
    end else begin
      room <= room_d;
      idle <= idle_d;
      irq  <= irq_d;
      dreq <= dreq_d;
    end
  end
endmodule

// File: rtl/tx_fifo_ctrl.sv
module tx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned DW   = tfifo_pkg::BYTE_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_dma,
  input  logic          frame_tick,
  input  logic          tx_en,
  input  logic [1:0]    trig_sel,
  input  logic          flush,
  input  logic          irq_en,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count,
  output logic          room_flag,
  output logic          idle_flag,
  output logic          dma_req,
  output logic          tx_irq
);
  logic [CW-1:0] occ, occ_after_pop, occ_next, trig;
  logic [DW-1:0] head;
  logic          pop, push;
  logic          vld_d;
  logic [DW-1:0] dat_d;

  assign trig          = CW'(tfifo_pkg::trig_level(trig_sel));
  assign pop           = frame_tick && tx_en && (occ != '0) && !flush;
  assign occ_after_pop = occ - CW'(pop);
  assign push          = wr_en && !flush && (occ_after_pop < CW'(DEPTH));
  assign occ_next      = occ_after_pop + CW'(push);

  tfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (wr_data),
    .pop       (pop),
    .clear     (flush),
    .head_data (head),
    .occ       (occ)
  );

  tfifo_flags #(.CW(CW)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (flush),
    .pop           (pop),
    .push          (push),
    .push_dma      (wr_dma),
    .occ_after_pop (occ_after_pop),
    .occ_next      (occ_next),
    .trig          (trig),
    .irq_en        (irq_en),
    .room          (room_flag),
    .idle          (idle_flag),
    .irq           (tx_irq),
    .dreq          (dma_req)
  );

  always_comb begin
    vld_d = pop;
    dat_d = out_data;
    if (pop) dat_d = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= dat_d;
    end
  end

  assign count = occ;
endmodule

// File: rtl/tx_fifo_chk.sv
module tx_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          frame_tick,
  input logic          tx_en,
  input logic          flush,
  input logic          irq_en,
  input logic          out_valid,
  input logic [CW-1:0] count,
  input logic          room_flag,
  input logic          idle_flag,
  input logic          tx_irq
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && wr_en && !frame_tick && !flush) |=> count == CW'(DEPTH));

  assert_pop_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && tx_en && count != '0 && !flush) |=> out_valid);

  assert_no_spurious_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_tick && tx_en && count != '0) |=> !out_valid);

  assert_idle_implies_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> room_flag);

  assert_flush_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && room_flag && idle_flag));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !tx_irq);
endmodule

bind tx_fifo_ctrl tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .frame_tick (frame_tick),
  .tx_en      (tx_en),
  .flush      (flush),
  .irq_en     (irq_en),
  .out_valid  (out_valid),
  .count      (count),
  .room_flag  (room_flag),
  .idle_flag  (idle_flag),
  .tx_irq     (tx_irq)
);

// File: tb/tb_tx_fifo_ctrl.sv
module tb_tx_fifo_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_dma, frame_tick, tx_en, flush, irq_en;
  logic [7:0] wr_data;
  logic [1:0] trig_sel;
  logic       out_valid, room_flag, idle_flag, dma_req, tx_irq;
  logic [7:0] out_data;
  logic [4:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  byte unsigned q[$];
  bit  m_room, m_idle, m_irq, m_dreq, m_vld;
  byte unsigned m_dat;

  always #2 clk = ~clk;

  tx_fifo_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_dma(wr_dma),
    .frame_tick(frame_tick), .tx_en(tx_en), .trig_sel(trig_sel), .flush(flush),
    .irq_en(irq_en), .out_valid(out_valid), .out_data(out_data), .count(count),
    .room_flag(room_flag), .idle_flag(idle_flag), .dma_req(dma_req), .tx_irq(tx_irq)
  );

  function automatic int trig_of(input logic [1:0] s);
    case (s)
      2'b00: return 8;
      2'b01: return 4;
      2'b10: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 count", count, q.size());
    chk("R6/R7 room_flag", room_flag, m_room);
    chk("R6/R7 idle_flag", idle_flag, m_idle);
    chk("R6/R9 tx_irq", tx_irq, m_irq);
    chk("R6/R8 dma_req", dma_req, m_dreq);
    chk("R4 out_valid", out_valid, m_vld);
    if (m_vld) chk("R2/R4 out_data", out_data, m_dat);
  endtask

  // Apply one cycle of stimulus, advance the model, then check after the edge.
  task automatic step(input bit w, input byte unsigned d, input bit dma, input bit tk,
                      input bit en, input logic [1:0] ts, input bit cl, input bit ie);
    int tr, after;
    bit pop, push;
    wr_en = w; wr_data = d; wr_dma = dma; frame_tick = tk; tx_en = en;
    trig_sel = ts; flush = cl; irq_en = ie;
    tr = trig_of(ts);
    m_dreq = 0;
    m_vld = 0;
    if (cl) begin                                   // R8
      q.delete();
      m_room = 1; m_idle = 1;
      if (ie) begin m_irq = 1; m_dreq = 1; end
    end else begin
      pop = tk && en && q.size() != 0;              // R4
      if (pop) begin
        m_vld = 1; m_dat = q.pop_front();
      end
      after = q.size();
      if (pop && after <= tr) begin                 // R5 R6 R10
        m_room = 1; m_dreq = 1;
        if (ie) m_irq = 1;
        if (after == 0) m_idle = 1;
      end
      push = w && after < 16;                       // R3
      if (push) begin
        q.push_back(d);
        if (dma) begin                              // R7
          m_idle = 0;
          if (q.size() > tr) begin m_room = 0; m_irq = 0; end
        end
      end
    end
    if (!ie) m_irq = 0;                             // R9
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d5a;
    void'($urandom(seed));
    rst_n = 0; wr_en = 0; wr_data = 0; wr_dma = 0; frame_tick = 0;
    tx_en = 0; trig_sel = 0; flush = 0; irq_en = 0;
    m_room = 1; m_idle = 1; m_irq = 0; m_dreq = 0; m_vld = 0; m_dat = 0;
    repeat (3) @(negedge clk);
    compare();                                      // R1 reset state
    rst_n = 1;
    @(negedge clk);
    compare();                                      // R1 held after release

    // R3: fill past capacity with DMA writes, trigger 8
    for (int i = 0; i < 20; i++) step(1, 8'(i + 8'h30), 1, 0, 1, 2'b00, 0, 1);
    // R4: ticks with transmit disabled do nothing
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 2'b00, 0, 1);
    // R6 R2: drain all with irq enabled, watermark 8
    for (int i = 0; i < 18; i++) step(0, 0, 0, 1, 1, 2'b00, 0, 1);
    // R7: CPU writes above watermark 1 keep flags set
    for (int i = 0; i < 4; i++) step(1, 8'(8'hA0 + i), 0, 0, 1, 2'b11, 0, 1);
    // R7: DMA writes crossing each watermark
    for (int s = 0; s < 4; s++) begin
      step(0, 0, 0, 0, 1, 2'b00, 1, 1);             // R8 flush
      for (int i = 0; i < 10; i++) step(1, 8'(i), 1, 0, 1, 2'(s), 0, 1);
      for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, 2'(s), 0, 1);
    end
    // R10: pop and write together at the watermark
    step(0, 0, 0, 0, 1, 2'b01, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 8'(i + 1), 1, 0, 1, 2'b01, 0, 1);
    for (int i = 0; i < 6; i++) step(1, 8'(i + 9), 1, 1, 1, 2'b01, 0, 1);
    // R8: flush with write and tick in the same cycle, irq disabled then enabled
    step(1, 8'h55, 1, 1, 1, 2'b01, 1, 0);
    step(1, 8'h56, 1, 1, 1, 2'b01, 1, 1);
    // Random phases with varying write and tick density
    for (int ph = 0; ph < 8; ph++) begin
      int wp, tp;
      wp = (ph % 2 == 0) ? 80 : 25;
      tp = (ph % 2 == 0) ? 30 : 70;
      for (int i = 0; i < 600; i++) begin
        step(($urandom % 100) < wp, 8'($urandom), $urandom % 2,
             ($urandom % 100) < tp, ($urandom % 8) != 0, 2'($urandom),
             ($urandom % 97) == 0, ($urandom % 6) != 0);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule